// File: doc/BRIEF.md
# Operand Address Former

This block turns the operand bytes of an already fetched instruction into the 16-bit address of its memory operand. It also reports when the instruction carries no address at all. The instruction sequencer supplies several values each time it presents an instruction:

- the addressing mode, already decoded from the opcode;
- the prefix byte, if one preceded the opcode;
- the one or two bytes that follow the opcode;
- the two index registers;
- the address of the next instruction.

One clock edge later the block presents three results: the address, a flag that says the address is meaningful, and a flag that says the operand is the immediate byte itself.

Six modes are covered:

- **Page-zero:** the high address byte is zero.
- **Absolute:** a full 16-bit address is carried in two bytes.
- **Index-relative:** an unsigned 8-bit displacement is added to an index register.
- **Branch-relative:** a signed 8-bit displacement is added to the next-instruction address.
- **Immediate and implied:** neither produces an address.

A prefix byte of 0x18 ahead of an index-relative instruction moves the base from the first index register to the second. Every sum wraps modulo 2^16.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and until the first instruction is accepted after reset, `ea_valid` and `imm_flag` are 0 and `ea` is 0x0000.
- R2: Results appear on the clock edge that samples `in_valid`=1. A cycle with `in_valid`=0 drives both `ea_valid` and `imm_flag` to 0 on the next edge.
- R3: Mode code 0 (implied) and the unused codes 6 and 7 give `ea_valid`=0, `imm_flag`=0 and `ea`=0x0000.
- R4: Mode code 1 (immediate) gives `imm_flag`=1, `ea_valid`=0 and `ea`=0x0000.
- R5: Mode code 2 (page-zero) gives `ea_valid`=1 and `ea` = {0x00, `op1`}.
- R6: Mode code 3 (absolute) gives `ea_valid`=1 and `ea` = {`op1`, `op2`}, with `op1` as the high byte.
- R7: Mode code 4 (index-relative) gives `ea_valid`=1 and `ea` = (`ix` + zero-extended `op1`) mod 2^16. This holds when there is no prefix, and also when the prefix is any value other than 0x18, such as 0x1A or 0xCD.
- R8: Mode code 4 with `pre_present`=1 and `pre_byte`=0x18 gives `ea` = (`iy` + zero-extended `op1`) mod 2^16.
- R9: Mode code 5 (branch-relative) gives `ea_valid`=1 and `ea` = (`pc_next` + sign-extended `op1`) mod 2^16.
- R10: A 0x18 prefix has no effect on modes other than code 4. Page-zero and branch-relative results are identical with and without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction operands presented this cycle |
| mode | input | 3 | Addressing mode code (0 implied, 1 immediate, 2 page-zero, 3 absolute, 4 index-relative, 5 branch-relative) |
| pre_present | input | 1 | A prefix byte preceded the opcode |
| pre_byte | input | 8 | Value of the prefix byte |
| op1 | input | 8 | First byte after the opcode |
| op2 | input | 8 | Second byte after the opcode |
| ix | input | 16 | First index register |
| iy | input | 16 | Second index register |
| pc_next | input | 16 | Address of the instruction that follows |
| ea_valid | output | 1 | `ea` holds an operand address |
| imm_flag | output | 1 | Operand is the immediate byte |
| ea | output | 16 | Effective address |

## Verification
Each of the three results is registered once, so all of them are due exactly one rising edge after the edge that samples `in_valid`. No combinational path reaches an output.

The bench changes inputs on the falling edge. It reads outputs on the following falling edge, after exactly one rising edge, and then drops `in_valid` so that the idle behaviour is checked on the cycle after.

Displacements 0x00, 0x7F, 0x80 and 0xFF are swept against bases chosen to cross 0xFFFF in both directions. The expected sums are computed with plain integer arithmetic in the bench.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_IMPL = 3'd0,
    MODE_IMM  = 3'd1,
    MODE_PAGE = 3'd2,
    MODE_ABS  = 3'd3,
    MODE_IDX  = 3'd4,
    MODE_BRL  = 3'd5
  } ea_mode_e;

  localparam logic [BYTE_W-1:0] PREFIX_ALT_INDEX = 8'h18;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ea_ofs_ext.sv
module ea_ofs_ext #(
  parameter int IN_W   = 8,
  parameter int OUT_W  = 16,
  parameter bit SIGNED = 1'b0
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (SIGNED) begin : g_sext
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
    end else begin : g_zext
      assign dout = {{PAD_W{1'b0}}, din};
    end
  endgenerate
endmodule

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              use_alt,
  input  logic [BW-1:0]     op1,
  input  logic [BW-1:0]     op2,
  input  logic [AW-1:0]     ix,
  input  logic [AW-1:0]     iy,
  input  logic [AW-1:0]     pc_next,
  output logic [AW-1:0]     base,
  output logic [AW-1:0]     ofs,
  output logic              is_addr,
  output logic              is_imm
);
  logic [AW-1:0] ofs_u;
  logic [AW-1:0] ofs_s;

  ea_ofs_ext #(.IN_W(BW), .OUT_W(AW), .SIGNED(1'b0)) u_zext (.din(op1), .dout(ofs_u));
  ea_ofs_ext #(.IN_W(BW), .OUT_W(AW), .SIGNED(1'b1)) u_sext (.din(op1), .dout(ofs_s));

  always_comb begin
    base    = '0;
    ofs     = '0;
    is_addr = 1'b0;
    is_imm  = 1'b0;
    case (mode)
      MODE_IMM: begin
        is_imm = 1'b1;
      end
      MODE_PAGE: begin
        ofs     = ofs_u;
        is_addr = 1'b1;
      end
      MODE_ABS: begin
        base    = AW'({op1, op2});
        is_addr = 1'b1;
      end
      MODE_IDX: begin
        base    = use_alt ? iy : ix;
        ofs     = ofs_u;
        is_addr = 1'b1;
      end
      MODE_BRL: begin
        base    = pc_next;
        ofs     = ofs_s;
        is_addr = 1'b1;
      end
      default: begin
        is_addr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic              pre_present,
  input  logic [BW-1:0]     pre_byte,
  input  logic [BW-1:0]     op1,
  input  logic [BW-1:0]     op2,
  input  logic [AW-1:0]     ix,
  input  logic [AW-1:0]     iy,
  input  logic [AW-1:0]     pc_next,
  output logic              ea_valid,
  output logic              imm_flag,
  output logic [AW-1:0]     ea
);
  logic          rst_sync_n;
  logic          use_alt;
  logic [AW-1:0] base, ofs, sum;
  logic          is_addr, is_imm;
  logic          valid_d, imm_d, ea_en;
  logic [AW-1:0] ea_d;
  logic          valid_q, imm_q;
  logic [AW-1:0] ea_q;

  ea_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_sync_n));

  assign use_alt = pre_present && (pre_byte == PREFIX_ALT_INDEX);

  ea_operand_sel #(.AW(AW), .BW(BW)) u_sel (
    .mode(mode), .use_alt(use_alt), .op1(op1), .op2(op2),
    .ix(ix), .iy(iy), .pc_next(pc_next),
    .base(base), .ofs(ofs), .is_addr(is_addr), .is_imm(is_imm)
  );

  assign sum = base + ofs;

  always_comb begin
    valid_d = in_valid && is_addr;
    imm_d   = in_valid && is_imm;
    ea_en   = in_valid;
    ea_d    = is_addr ? sum : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      imm_q   <= 1'b0;
      ea_q    <= '0;
    end else begin
      valid_q <= valid_d;
      imm_q   <= imm_d;
      if (ea_en) ea_q <= ea_d;
    end
  end

  assign ea_valid = valid_q;
  assign imm_flag = imm_q;
  assign ea       = ea_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MODE_W-1:0] mode,
  input logic              pre_present,
  input logic [BW-1:0]     pre_byte,
  input logic [BW-1:0]     op1,
  input logic [BW-1:0]     op2,
  input logic [AW-1:0]     ix,
  input logic [AW-1:0]     iy,
  input logic [AW-1:0]     pc_next,
  input logic              ea_valid,
  input logic              imm_flag,
  input logic [AW-1:0]     ea
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!ea_valid && !imm_flag));
  // R3
  implied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == MODE_IMPL || mode > MODE_BRL)) |=> (!ea_valid && !imm_flag && ea == '0));
  // R4
  imm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_IMM) |=> (imm_flag && !ea_valid && ea == '0));
  // R5
  page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_PAGE) |=> (ea_valid && ea[AW-1:BW] == '0 && ea[BW-1:0] == $past(op1)));
  // R6
  abs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_ABS) |=> (ea_valid && ea[AW-1:BW] == $past(op1) && ea[BW-1:0] == $past(op2)));
  // R8
  alt_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_IDX && pre_present && pre_byte == PREFIX_ALT_INDEX)
      |=> (ea_valid && ea == AW'($past(iy) + AW'($past(op1)))));
  // R1 and R2: never both flags at once
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && imm_flag));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .BW(BW)) u_ea_gen_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .mode(mode),
  .pre_present(pre_present), .pre_byte(pre_byte), .op1(op1), .op2(op2),
  .ix(ix), .iy(iy), .pc_next(pc_next),
  .ea_valid(ea_valid), .imm_flag(imm_flag), .ea(ea)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic        pre_present;
  logic [7:0]  pre_byte, op1, op2;
  logic [15:0] ix, iy, pc_next;
  logic        ea_valid, imm_flag;
  logic [15:0] ea;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .pre_present(pre_present), .pre_byte(pre_byte), .op1(op1), .op2(op2),
    .ix(ix), .iy(iy), .pc_next(pc_next),
    .ea_valid(ea_valid), .imm_flag(imm_flag), .ea(ea)
  );

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Present one instruction at a falling edge, read results one rising edge later.
  task automatic issue(input logic [2:0] m, input logic pp, input logic [7:0] pb,
                       input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; mode = m; pre_present = pp; pre_byte = pb; op1 = a; op2 = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] add_u(input logic [15:0] base, input logic [7:0] o);
    int s;
    s = (int'(base) + int'(o)) % 65536;
    return 16'(s);
  endfunction

  function automatic logic [15:0] add_s(input logic [15:0] base, input logic [7:0] o);
    int s;
    s = int'(base) + ((o >= 8'd128) ? int'(o) - 256 : int'(o));
    s = (s + 65536) % 65536;
    return 16'(s);
  endfunction

  initial begin
    logic [7:0]  offs  [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    logic [15:0] bases [5] = '{16'h0000, 16'h1234, 16'h8000, 16'hFF80, 16'hFFFF};
    logic [15:0] ref_page;
    rst_n = 1'b0; in_valid = 1'b0; mode = 3'd0; pre_present = 1'b0; pre_byte = 8'h00;
    op1 = 8'h00; op2 = 8'h00; ix = 16'h0; iy = 16'h0; pc_next = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {ea_valid, imm_flag, 15'h0}, 17'h0);
    chk("R1", {1'b0, ea}, 17'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {ea_valid, imm_flag, ea[14:0]}, 17'h0);

    // R4 immediate
    issue(3'd1, 1'b0, 8'h00, 8'h5C, 8'h00);
    chk("R4", {imm_flag, ea_valid, 15'h0}, {1'b1, 16'h0});
    chk("R4", {1'b0, ea}, 17'h0);
    @(negedge clk);
    // R2 idle clears flags
    chk("R2", {15'h0, imm_flag, ea_valid}, 17'h0);

    // R3 implied and unused codes
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m >= 6) begin
        issue(3'd2, 1'b0, 8'h00, 8'hAA, 8'h00);
        issue(3'(m), 1'b0, 8'h00, 8'h33, 8'h44);
        chk("R3", {ea_valid, imm_flag, ea[14:0]}, 17'h0);
        chk("R3", {1'b0, ea}, 17'h0);
      end
    end

    // R5 page-zero and R10 prefix ignored there
    for (int v = 0; v < 256; v += 17) begin
      ref_page = {8'h00, 8'(v)};
      issue(3'd2, 1'b0, 8'h00, 8'(v), 8'hEE);
      chk("R5", {ea_valid, ea}, {1'b1, ref_page});
      issue(3'd2, 1'b1, 8'h18, 8'(v), 8'hEE);
      chk("R10", {ea_valid, ea}, {1'b1, ref_page});
    end
    @(negedge clk);
    chk("R2", {15'h0, imm_flag, ea_valid}, 17'h0);

    // R6 absolute, first byte high
    issue(3'd3, 1'b0, 8'h00, 8'h6D, 8'h00);
    chk("R6", {ea_valid, ea}, {1'b1, 16'h6D00});
    issue(3'd3, 1'b0, 8'h00, 8'h01, 8'hFE);
    chk("R6", {ea_valid, ea}, {1'b1, 16'h01FE});

    // R7 R8 R9 R10 offset sweeps against wrapping bases
    for (int bi = 0; bi < 5; bi++) begin
      for (int oi = 0; oi < 4; oi++) begin
        ix = bases[bi]; iy = bases[4 - bi] ^ 16'h0F0F; pc_next = bases[bi];
        issue(3'd4, 1'b0, 8'h00, offs[oi], 8'h00);
        chk("R7", {ea_valid, ea}, {1'b1, add_u(ix, offs[oi])});
        issue(3'd4, 1'b1, 8'h1A, offs[oi], 8'h00);
        chk("R7", {ea_valid, ea}, {1'b1, add_u(ix, offs[oi])});
        issue(3'd4, 1'b1, 8'hCD, offs[oi], 8'h00);
        chk("R7", {ea_valid, ea}, {1'b1, add_u(ix, offs[oi])});
        issue(3'd4, 1'b1, 8'h18, offs[oi], 8'h00);
        chk("R8", {ea_valid, ea}, {1'b1, add_u(iy, offs[oi])});
        issue(3'd5, 1'b0, 8'h00, offs[oi], 8'h00);
        chk("R9", {ea_valid, ea}, {1'b1, add_s(pc_next, offs[oi])});
        issue(3'd5, 1'b1, 8'h18, offs[oi], 8'h00);
        chk("R10", {ea_valid, ea}, {1'b1, add_s(pc_next, offs[oi])});
      end
    end
    @(negedge clk);
    chk("R2", {15'h0, imm_flag, ea_valid}, 17'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule